// File: doc/BRIEF.md
# Supply monitor reset controller

This block is the digital control around a supply comparator. It decides when the core is held in reset and reports why the last reset happened. A power-on event loads the monitor configuration, enabled and acting as a reset source, and holds the core in reset for a fixed power-on delay. After that, the comparator's "supply low" output, once passed through a synchronizer, holds the core in reset for as long as the supply stays low. Software can ask for a short fixed reset pulse. The monitor configuration keeps its value through every reset except power-on.

The block also gates flash erase and write requests. A request is passed to the flash array as a strobe, and acknowledged one cycle later, only while the monitor is enabled and the core is out of reset. Otherwise the request is dropped without any response. When the monitor is first enabled it needs time to settle. During this time its output is treated as "supply low", so if the monitor is selected as a reset source too early, a reset follows.

Top module: `svmon_rst_ctrl`

## Requirements
- R1: After `por_n` rises, `core_rst` stays 1 and falls on the POR_CYCLES-th rising clock edge; from power-on `cfg_rdata` reads 2'b11 (bit 0 enable, bit 1 select), `stat_por` reads 1 and `stat_sw` reads 0.
- R2: While `por_n` is 0, `core_rst` is 1 without waiting for a clock edge.
- R3: With enable and select both 1, `core_rst` rises on the third rising edge after `supply_low_async` goes high, and stays 1 while it stays high; `stat_por` then reads 1.
- R4: `core_rst` falls on the third rising edge after `supply_low_async` returns low, with no power-on delay.
- R5: A `sw_rst_req` sampled while `core_rst` is 0 (and no monitor trip) drives `core_rst` high for exactly SW_CYCLES cycles, sets `stat_sw` to 1 and clears `stat_por`; `stat_sw` stays 1 until the next reset.
- R6: Software and monitor resets leave the enable and select bits unchanged.
- R7: A write whose bit 1 is 1 while the current enable bit is 0 leaves select at 0; the enable bit takes bit 0 of the written value.
- R8: `flash_strobe` equals `flash_req` when enable is 1 and `core_rst` is 0, and is 0 otherwise; `flash_ack` is the strobe delayed by one clock.
- R9: For SETTLE_CYCLES cycles after enable goes from 0 to 1, the comparator reads as low, so selecting the monitor in that window causes a reset until the window ends; selecting it afterwards causes none.
- R10: When a software request and a monitor trip fall on the same edge, the monitor wins: `stat_por` is 1 and no software pulse follows the trip.
- R11: Configuration writes are ignored while `core_rst` is 1, and a low supply has no effect while enable or select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| supply_low_async | input | 1 | Comparator output, 1 when the supply is below threshold, asynchronous |
| sw_rst_req | input | 1 | Software reset request |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 2 | Write data: bit 0 enable, bit 1 select |
| cfg_rdata | output | 2 | Current configuration: bit 0 enable, bit 1 select |
| flash_req | input | 1 | Flash erase or write request |
| flash_strobe | output | 1 | Request passed on to the flash array |
| flash_ack | output | 1 | Acknowledge, one cycle after the strobe |
| core_rst | output | 1 | Core reset, active high |
| stat_por | output | 1 | Status: last reset was power-on or monitor |
| stat_sw | output | 1 | Status: last reset was a software request |

## Verification
Two functions can act on the same clock edge. First, a software request can reach the block on the edge where the synchronized supply-low indication first trips the monitor. The bench drives the request exactly two edges after raising the comparator input. It then judges the result by the power-on flag and by `core_rst` falling three edges after the supply recovers, which it would not do if a 16-cycle software pulse had started. Second, a flash request can arrive in the cycle in which a configuration write clears enable. In the random phase the writes and requests overlap. A bench model decides each strobe from the enable value held before that edge.

// File: rtl/svmon_pkg.sv
package svmon_pkg;

  // Configuration word: bit 0 monitor enable, bit 1 reset-source select.
  typedef struct packed {
    logic sel;
    logic en;
  } mon_cfg_t;

  // Status word: bit 0 power-on/monitor cause, bit 1 software cause.
  typedef struct packed {
    logic sw;
    logic por;
  } rst_flags_t;

  localparam mon_cfg_t   CFG_POWER_ON   = '{sel: 1'b1, en: 1'b1};
  localparam rst_flags_t FLAGS_POWER_ON = '{sw: 1'b0, por: 1'b1};
  localparam rst_flags_t FLAGS_SOFTWARE = '{sw: 1'b1, por: 1'b0};

  // Select may only be set while enable is already set.
  function automatic mon_cfg_t cfg_apply(mon_cfg_t cur, logic [1:0] wd);
    mon_cfg_t nxt;
    nxt.en  = wd[0];
    nxt.sel = wd[1] & cur.en;
    return nxt;
  endfunction

  // The monitor trips when it is both enabled and selected and the
  // supply reads low, or the comparator has not yet settled.
  function automatic logic trip_cond(mon_cfg_t c, logic low, logic settling);
    return c.en & c.sel & (low | settling);
  endfunction

endpackage

// File: rtl/svmon_sync.sv
module svmon_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= {STAGES{INIT}};
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/svmon_cfg.sv
module svmon_cfg
  import svmon_pkg::*;
#(
  parameter int SETTLE_CYCLES = 32
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       core_rst,
  input  logic       we,
  input  logic [1:0] wdata,
  input  logic       supply_low,
  output mon_cfg_t   cfg,
  output logic       settling,
  output logic       mon_trip
);

  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_CYCLES);

  mon_cfg_t      cfg_q;
  logic [SW-1:0] settle_cnt;

  // Only power-on resets the configuration; other resets block writes.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                cfg_q <= CFG_POWER_ON;
    else if (we && !core_rst)  cfg_q <= cfg_apply(cfg_q, wdata);
  end

  // The settle window restarts whenever enable is seen as 0.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                settle_cnt <= SETTLE_LOAD;
    else if (!cfg_q.en)        settle_cnt <= SETTLE_LOAD;
    else if (settle_cnt != '0) settle_cnt <= settle_cnt - 1'b1;
  end

  assign settling = cfg_q.en && (settle_cnt != '0);
  assign mon_trip = trip_cond(cfg_q, supply_low, settling);
  assign cfg      = cfg_q;

  p_sel_needs_en_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cfg_q.sel) |-> $past(cfg_q.en));

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |=> $stable(cfg_q));

  p_settle_start_r9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cfg_q.en) |-> settling);

endmodule

// File: rtl/svmon_seq.sv
module svmon_seq
  import svmon_pkg::*;
#(
  parameter int POR_CYCLES = 1024,
  parameter int SW_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       mon_trip,
  input  logic       sw_req,
  output logic       core_rst,
  output rst_flags_t flags
);

  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam int WW = $clog2(SW_CYCLES + 1);
  localparam logic [PW-1:0] POR_LOAD = PW'(POR_CYCLES);
  localparam logic [WW-1:0] SW_LOAD  = WW'(SW_CYCLES);

  logic [PW-1:0] por_cnt, por_nxt;
  logic [WW-1:0] sw_cnt, sw_nxt;
  logic          core_rst_q, rst_nxt;
  logic          sw_accept;
  rst_flags_t    flags_q;

  function automatic logic [PW-1:0] por_step(logic [PW-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  function automatic logic [WW-1:0] sw_step(logic [WW-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  // A software request counts only from a running core and loses to a trip.
  assign sw_accept = sw_req && !core_rst_q && !mon_trip;
  assign por_nxt   = por_step(por_cnt);
  assign sw_nxt    = sw_accept ? SW_LOAD : sw_step(sw_cnt);
  assign rst_nxt   = (por_nxt != '0) || mon_trip || (sw_nxt != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      por_cnt    <= POR_LOAD;
      sw_cnt     <= '0;
      core_rst_q <= 1'b1;
    end else begin
      por_cnt    <= por_nxt;
      sw_cnt     <= sw_nxt;
      core_rst_q <= rst_nxt;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         flags_q <= FLAGS_POWER_ON;
    else if (mon_trip)  flags_q <= FLAGS_POWER_ON;
    else if (sw_accept) flags_q <= FLAGS_SOFTWARE;
  end

  assign core_rst = core_rst_q;
  assign flags    = flags_q;

  p_por_hold_r1: assert property (@(posedge clk) disable iff (!por_n)
    (por_cnt != '0) |-> core_rst_q);

  p_mon_rst_r3: assert property (@(posedge clk) disable iff (!por_n)
    mon_trip |=> (core_rst_q && flags_q.por));

  p_no_por_delay_r4: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(mon_trip) && por_cnt == '0 && sw_cnt == '0) |=> !core_rst_q);

  p_sw_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
    sw_accept |=> (core_rst_q && flags_q.sw && !flags_q.por));

  p_trip_wins_r10: assert property (@(posedge clk) disable iff (!por_n)
    (sw_req && mon_trip) |=> !flags_q.sw);

endmodule

// File: rtl/svmon_rst_ctrl.sv
module svmon_rst_ctrl
  import svmon_pkg::*;
#(
  parameter int POR_CYCLES    = 1024,
  parameter int SETTLE_CYCLES = 32,
  parameter int SW_CYCLES     = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       supply_low_async,
  input  logic       sw_rst_req,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wdata,
  output logic [1:0] cfg_rdata,
  input  logic       flash_req,
  output logic       flash_strobe,
  output logic       flash_ack,
  output logic       core_rst,
  output logic       stat_por,
  output logic       stat_sw
);

  logic       supply_low;
  logic       settling;
  logic       mon_trip;
  mon_cfg_t   cfg;
  rst_flags_t flags;
  logic       ack_q;

  // Resets to "low" so that the supply is treated as unsafe until it is seen.
  svmon_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      (supply_low_async),
    .q      (supply_low)
  );

  svmon_cfg #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_cfg (
    .clk        (clk),
    .por_n      (por_n),
    .core_rst   (core_rst),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .supply_low (supply_low),
    .cfg        (cfg),
    .settling   (settling),
    .mon_trip   (mon_trip)
  );

  svmon_seq #(.POR_CYCLES(POR_CYCLES), .SW_CYCLES(SW_CYCLES)) u_seq (
    .clk      (clk),
    .por_n    (por_n),
    .mon_trip (mon_trip),
    .sw_req   (sw_rst_req),
    .core_rst (core_rst),
    .flags    (flags)
  );

  // Flash gate: requests pass only with the monitor enabled and the core running.
  assign flash_strobe = flash_req && cfg.en && !core_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) ack_q <= 1'b0;
    else        ack_q <= flash_strobe;
  end

  assign flash_ack = ack_q;
  assign cfg_rdata = cfg;
  assign stat_por  = flags.por;
  assign stat_sw   = flags.sw;

  p_ack_after_strobe_r8: assert property (@(posedge clk) disable iff (!por_n)
    flash_ack |-> $past(flash_strobe));

  p_trip_only_selected_r11: assert property (@(posedge clk) disable iff (!por_n)
    mon_trip |-> (cfg_rdata == 2'b11));

endmodule

// File: tb/svmon_rst_ctrl_test.sv
module svmon_rst_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int POR_C      = 40;
  localparam int SETTLE_C   = 12;
  localparam int SW_C       = 16;

  logic       clk = 1'b0;
  logic       por_n = 1'b1;
  logic       supply_low_async = 1'b0;
  logic       sw_rst_req = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic [1:0] cfg_rdata;
  logic       flash_req = 1'b0;
  logic       flash_strobe, flash_ack, core_rst, stat_por, stat_sw;

  int total = 0;
  int bad   = 0;

  svmon_rst_ctrl #(.POR_CYCLES(POR_C), .SETTLE_CYCLES(SETTLE_C),
                   .SW_CYCLES(SW_C), .SYNC_STAGES(2)) uut (
    .clk(clk), .por_n(por_n), .supply_low_async(supply_low_async),
    .sw_rst_req(sw_rst_req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .flash_req(flash_req), .flash_strobe(flash_strobe),
    .flash_ack(flash_ack), .core_rst(core_rst), .stat_por(stat_por),
    .stat_sw(stat_sw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: through the rising edge, back to the falling edge.
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write_cfg(input logic [1:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick(1);
    cfg_we = 1'b0;
  endtask

  // Bench's own view of the flash gate and of the select rule.
  function automatic logic exp_strobe(logic req, logic en, logic rst);
    return req & en & ~rst;
  endfunction

  function automatic logic [1:0] exp_cfg(logic [1:0] cur, logic [1:0] wd);
    return {wd[1] & cur[0], wd[0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic       m_en, m_req, m_rst, m_strobe_prev, m_we, m_sw;
    logic [1:0] m_wd;
    int         m_sw_left;

    void'($urandom(32'h5EED));
    #3 por_n = 1'b0;
    #1;
    chk("R2 async reset assert", core_rst, 1'b1);
    tick(3);
    chk("R1 cfg after power-on", cfg_rdata, 2'b11);
    chk("R1 por flag", stat_por, 1'b1);
    chk("R1 sw flag clear", stat_sw, 1'b0);
    por_n = 1'b1;
    tick(5);
    cfg_we = 1'b1; cfg_wdata = 2'b00;   // R11: write during reset
    tick(1);
    cfg_we = 1'b0;
    tick(POR_C - 7);
    chk("R1 reset held through delay", core_rst, 1'b1);
    tick(1);
    chk("R1 reset released", core_rst, 1'b0);
    chk("R11 write in reset ignored", cfg_rdata, 2'b11);

    // Software reset pulse
    sw_rst_req = 1'b1; tick(1); sw_rst_req = 1'b0;
    chk("R5 sw reset asserted", core_rst, 1'b1);
    chk("R5 sw flag set", stat_sw, 1'b1);
    chk("R5 por flag cleared", stat_por, 1'b0);
    tick(SW_C - 1);
    chk("R5 sw pulse last cycle", core_rst, 1'b1);
    tick(1);
    chk("R5 sw pulse ended", core_rst, 1'b0);
    chk("R6 cfg after sw reset", cfg_rdata, 2'b11);
    tick(5);
    chk("R5 sw flag persists", stat_sw, 1'b1);

    // Monitor trip
    supply_low_async = 1'b1;
    tick(2);
    chk("R3 not yet through sync", core_rst, 1'b0);
    tick(1);
    chk("R3 monitor reset", core_rst, 1'b1);
    chk("R3 por flag after trip", stat_por, 1'b1);
    tick(20);
    chk("R3 held while low", core_rst, 1'b1);
    supply_low_async = 1'b0;
    tick(2);
    chk("R4 still held in sync", core_rst, 1'b1);
    tick(1);
    chk("R4 release without delay", core_rst, 1'b0);
    chk("R4 por flag", stat_por, 1'b1);
    chk("R6 cfg after monitor reset", cfg_rdata, 2'b11);

    // Same-edge software request and trip
    supply_low_async = 1'b1;
    tick(2);
    sw_rst_req = 1'b1; tick(1); sw_rst_req = 1'b0;
    chk("R10 reset on shared edge", core_rst, 1'b1);
    chk("R10 monitor cause wins", stat_por, 1'b1);
    tick(4);
    supply_low_async = 1'b0;
    tick(3);
    chk("R10 no sw pulse after trip", core_rst, 1'b0);

    // Select cleared: low supply ignored
    write_cfg(2'b01);
    chk("R11 cfg enable only", cfg_rdata, 2'b01);
    supply_low_async = 1'b1;
    tick(6);
    chk("R11 low ignored without select", core_rst, 1'b0);
    supply_low_async = 1'b0;
    tick(3);

    // Select needs enable
    write_cfg(2'b00);
    chk("R7 cleared", cfg_rdata, 2'b00);
    write_cfg(2'b10);
    chk("R7 select without enable ignored", cfg_rdata, exp_cfg(2'b00, 2'b10));
    flash_req = 1'b1;
    #1;
    chk("R8 strobe blocked when disabled", flash_strobe, 1'b0);
    tick(1);
    flash_req = 1'b0;
    chk("R8 no ack when disabled", flash_ack, 1'b0);

    // Select during settling
    write_cfg(2'b01);
    write_cfg(2'b11);
    chk("R9 select accepted", cfg_rdata, 2'b11);
    tick(1);
    chk("R9 settling trip", core_rst, 1'b1);
    tick(SETTLE_C - 2);
    chk("R9 held to end of window", core_rst, 1'b1);
    tick(1);
    chk("R9 released after window", core_rst, 1'b0);

    // Select after settling
    write_cfg(2'b00);
    write_cfg(2'b01);
    tick(SETTLE_C + 2);
    write_cfg(2'b11);
    tick(3);
    chk("R9 no trip once settled", core_rst, 1'b0);

    // Random flash / config / software-reset mix with select kept 0
    write_cfg(2'b01);
    m_en = 1'b1; m_sw_left = 0; m_strobe_prev = 1'b0;
    tick(1);
    m_strobe_prev = 1'b0;
    for (int it = 0; it < 300; it++) begin
      m_req = 1'($urandom % 2);
      m_we  = (($urandom % 4) == 0);
      m_wd  = {1'b0, 1'($urandom % 2)};
      m_sw  = (($urandom % 32) == 0);
      flash_req = m_req; cfg_we = m_we; cfg_wdata = m_wd; sw_rst_req = m_sw;
      m_rst = (m_sw_left > 0);
      #1;
      chk("R5 core reset model", core_rst, m_rst);
      chk("R8 strobe gate", flash_strobe, exp_strobe(m_req, m_en, m_rst));
      chk("R8 ack delay", flash_ack, m_strobe_prev);
      m_strobe_prev = exp_strobe(m_req, m_en, m_rst);
      if (m_we && !m_rst) m_en = m_wd[0];
      if (m_sw && !m_rst) m_sw_left = SW_C;
      else if (m_sw_left > 0) m_sw_left--;
      tick(1);
    end
    flash_req = 1'b0; cfg_we = 1'b0; sw_rst_req = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule